// File: doc/BRIEF.md
# Single-Overtake Issue Queue

This block holds up to eight decoded instructions in arrival order and picks, every cycle, at most one of them to issue. In the normal case the oldest entry (the head) leaves as soon as both of its source registers are marked ready in the register scoreboard. When the head is stuck on a register whose value is still pending, the block looks at exactly one more entry, the one directly behind the head. That entry is allowed to overtake only if it is independent of the head and its own sources are ready. No deeper search is made, so the cost of the out-of-order step stays at a handful of register-index comparators.

An entry carries a branch flag, a write-enable flag, a destination register, two source registers and an opaque payload. Upstream logic pushes entries with a valid/ready handshake. Downstream logic takes the chosen entry with a second valid/ready handshake, and a selector output tells which position was taken. When the entry behind the head is taken, it is removed and the entries behind it close the gap; the head stays at the front. Register readiness arrives as one flag per architectural register and acts within the same cycle.

The controller is a three-state machine on the queue occupancy. `Q_EMPTY` (nothing held, nothing issues) moves to `Q_SINGLE` on a push. `Q_SINGLE` (only the head exists, so only the head may issue) moves to `Q_MULTI` on a push without a pop, to `Q_EMPTY` on a pop without a push, and stays put otherwise. `Q_MULTI` (two or more entries, so the overtake check is active) moves to `Q_SINGLE` when a pop without a push leaves one entry, and stays put otherwise.

Top module: `peek_issue_queue`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0 and `in_ready` is 1.
- R2: Entries are accepted while fewer than 8 are held; with 8 held `in_ready` is 0 and a push attempt is ignored. With every register ready, entries leave in push order.
- R3: If the head has both sources ready it is offered with `iss_sel` = 0 (head), whatever the entry behind it holds.
- R4: If the head is blocked and the entry behind it is independent, not a branch, and has both sources ready, that entry is offered with `iss_sel` = 1 (second).
- R5: The second entry may not overtake when the head writes a register (write flag 1) and the second entry reads that register as either source.
- R6: The second entry may not overtake when both entries write and their destination registers are equal.
- R7: The second entry writing a register the head reads does not block the overtake when that head source is ready, and does block it when that head source is pending.
- R8: The second entry may not overtake unless both of its own sources are ready.
- R9: A branch entry (branch flag 1) never overtakes, and no entry overtakes a head that is a branch.
- R10: At most one entry leaves per cycle and only when `iss_ready` is 1; after an overtake the blocked head stays at the front and the remaining entries keep their order.
- R11: Only the entry directly behind the head is ever examined; an eligible third entry is not offered while the head is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | Queue has room |
| in_br | input | 1 | Pushed entry is a branch |
| in_wr | input | 1 | Pushed entry writes its destination |
| in_dst | input | RW | Destination register of pushed entry |
| in_src_a | input | RW | First source register of pushed entry |
| in_src_b | input | RW | Second source register of pushed entry |
| in_pay | input | PAYW | Opaque payload of pushed entry |
| reg_rdy | input | NREG | Bit i set means register i holds its final value |
| iss_valid | output | 1 | An entry is offered for issue |
| iss_ready | input | 1 | Consumer takes the offered entry |
| iss_sel | output | 1 | 0 = head offered, 1 = second entry offered |
| iss_br | output | 1 | Branch flag of offered entry |
| iss_wr | output | 1 | Write flag of offered entry |
| iss_dst | output | RW | Destination of offered entry |
| iss_src_a | output | RW | First source of offered entry |
| iss_src_b | output | RW | Second source of offered entry |
| iss_pay | output | PAYW | Payload of offered entry |

## Verification
A pushed entry sits in the queue from the clock edge that accepts it, so its effect on the issue outputs is due one edge after the push; the choice between head and second entry depends on `reg_rdy` combinationally and is due in the same cycle the flags change. The bench therefore drives inputs just after a rising edge, lets them settle, and samples the offer before the next edge. A removal shows up one edge after a cycle with `iss_valid` and `iss_ready` both high, so order checks step one edge per issued entry. The hazard rules are swept over every assignment of three registers to the six register fields of a head/second pair, both write-flag settings of the second entry and all readiness patterns of those registers.

// File: rtl/pkq_pkg.sv
package pkq_pkg;

    // occupancy class seen by the issue controller
    typedef enum logic [1:0] {
        Q_EMPTY  = 2'd0,
        Q_SINGLE = 2'd1,
        Q_MULTI  = 2'd2
    } occ_t;

    // which queue position is offered
    typedef enum logic {
        PICK_HEAD = 1'b0,
        PICK_NEXT = 1'b1
    } pick_t;

endpackage

// File: rtl/pkq_store.sv
module pkq_store #(
    parameter int DEPTH = 8,
    parameter int EW    = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_ent,
    input  logic          pop,
    input  logic          pop_idx,
    output logic [CW-1:0] cnt,
    output logic [EW-1:0] ent0,
    output logic [EW-1:0] ent1
);

    logic [EW-1:0] slot [DEPTH];
    logic [CW-1:0] wr_idx;

    // after a pop the tail moves down one place, so the write lands one lower
    assign wr_idx = cnt - CW'(pop);

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            logic [EW-1:0] shift_in;
            if (g < DEPTH - 1) begin : g_mid
                assign shift_in = slot[g+1];
            end else begin : g_last
                assign shift_in = slot[g];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot[g] <= '0;
                end else if (push && (wr_idx == CW'(g))) begin
                    slot[g] <= push_ent;
                end else if (pop && (CW'(g) >= CW'(pop_idx))) begin
                    slot[g] <= shift_in;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign ent0 = slot[0];
    assign ent1 = slot[1];

    // R2: never written past capacity
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CW'(DEPTH) || pop));

    // R10: removal only from a non-empty queue
    a_r10_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));

    // R10: removing the second entry leaves the head untouched
    a_r10_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && pop_idx) |=> $stable(slot[0]));

endmodule

// File: rtl/pkq_hazard.sv
module pkq_hazard #(
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] rdy,
    input  logic            h_br,
    input  logic            h_wr,
    input  logic [RW-1:0]   h_dst,
    input  logic [RW-1:0]   h_sa,
    input  logic [RW-1:0]   h_sb,
    input  logic            n_br,
    input  logic            n_wr,
    input  logic [RW-1:0]   n_dst,
    input  logic [RW-1:0]   n_sa,
    input  logic [RW-1:0]   n_sb,
    output logic            head_go,
    output logic            next_clear
);

    logic h_a_ok, h_b_ok, n_ops_ok;
    logic true_dep, out_dep, anti_block, branch_block;

    always_comb begin
        h_a_ok   = rdy[h_sa];
        h_b_ok   = rdy[h_sb];
        head_go  = h_a_ok && h_b_ok;
        n_ops_ok = rdy[n_sa] && rdy[n_sb];

        // second entry reads what the head will produce
        true_dep = h_wr && ((n_sa == h_dst) || (n_sb == h_dst));
        // both produce the same register
        out_dep  = h_wr && n_wr && (n_dst == h_dst);
        // second overwrites a head source the head has not captured yet
        anti_block = n_wr && (((n_dst == h_sa) && !h_a_ok) ||
                              ((n_dst == h_sb) && !h_b_ok));
        branch_block = h_br || n_br;

        next_clear = n_ops_ok && !true_dep && !out_dep &&
                     !anti_block && !branch_block;
    end

endmodule

// File: rtl/pkq_ctrl.sv
module pkq_ctrl
    import pkq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          push,
    input  logic          pop,
    input  logic          head_go,
    input  logic          next_clear,
    output logic          offer,
    output pick_t         pick
);

    occ_t          state, state_nx;
    logic [CW-1:0] cnt_nx;

    // next-state logic
    always_comb begin
        cnt_nx   = cnt + CW'(push) - CW'(pop);
        state_nx = state;
        unique case (state)
            Q_EMPTY: begin
                if (push) state_nx = Q_SINGLE;
            end
            Q_SINGLE: begin
                if (push && !pop)      state_nx = Q_MULTI;
                else if (pop && !push) state_nx = Q_EMPTY;
            end
            Q_MULTI: begin
                if (cnt_nx == CW'(1)) state_nx = Q_SINGLE;
            end
            default: state_nx = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        offer = 1'b0;
        pick  = PICK_HEAD;
        unique case (state)
            Q_EMPTY: begin
                offer = 1'b0;
            end
            Q_SINGLE: begin
                offer = head_go;
            end
            Q_MULTI: begin
                if (head_go) begin
                    offer = 1'b1;
                end else if (next_clear) begin
                    offer = 1'b1;
                    pick  = PICK_NEXT;
                end
            end
            default: offer = 1'b0;
        endcase
    end

    // R1: controller state tracks the stored entry count
    a_r1_state_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EMPTY) == (cnt == '0));

    // R11: overtake only when a second entry exists
    a_r11_multi_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_NEXT) |-> (cnt >= CW'(2)));

    // R2: count stays within capacity
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/peek_issue_queue.sv
module peek_issue_queue
    import pkq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NREG  = 16,
    parameter int PAYW  = 8,
    parameter int RW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_br,
    input  logic            in_wr,
    input  logic [RW-1:0]   in_dst,
    input  logic [RW-1:0]   in_src_a,
    input  logic [RW-1:0]   in_src_b,
    input  logic [PAYW-1:0] in_pay,
    input  logic [NREG-1:0] reg_rdy,
    output logic            iss_valid,
    input  logic            iss_ready,
    output logic            iss_sel,
    output logic            iss_br,
    output logic            iss_wr,
    output logic [RW-1:0]   iss_dst,
    output logic [RW-1:0]   iss_src_a,
    output logic [RW-1:0]   iss_src_b,
    output logic [PAYW-1:0] iss_pay
);

    localparam int CW     = $clog2(DEPTH + 1);
    localparam int EW     = 2 + 3 * RW + PAYW;
    localparam int O_PAY  = 0;
    localparam int O_SB   = O_PAY + PAYW;
    localparam int O_SA   = O_SB + RW;
    localparam int O_DST  = O_SA + RW;
    localparam int O_WR   = O_DST + RW;
    localparam int O_BR   = O_WR + 1;

    logic [CW-1:0] cnt;
    logic [EW-1:0] ent0, ent1, push_ent, pick_ent;
    logic          push, pop;
    logic          head_go, next_clear, offer;
    pick_t         pick;

    assign in_ready = (cnt < CW'(DEPTH));
    assign push     = in_valid && in_ready;
    assign push_ent = {in_br, in_wr, in_dst, in_src_a, in_src_b, in_pay};
    assign pop      = offer && iss_ready;

    pkq_store #(.DEPTH(DEPTH), .EW(EW), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .pop_idx  (pick == PICK_NEXT),
        .cnt      (cnt),
        .ent0     (ent0),
        .ent1     (ent1)
    );

    pkq_hazard #(.NREG(NREG), .RW(RW)) u_hazard (
        .rdy        (reg_rdy),
        .h_br       (ent0[O_BR]),
        .h_wr       (ent0[O_WR]),
        .h_dst      (ent0[O_DST +: RW]),
        .h_sa       (ent0[O_SA +: RW]),
        .h_sb       (ent0[O_SB +: RW]),
        .n_br       (ent1[O_BR]),
        .n_wr       (ent1[O_WR]),
        .n_dst      (ent1[O_DST +: RW]),
        .n_sa       (ent1[O_SA +: RW]),
        .n_sb       (ent1[O_SB +: RW]),
        .head_go    (head_go),
        .next_clear (next_clear)
    );

    pkq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .push       (push),
        .pop        (pop),
        .head_go    (head_go),
        .next_clear (next_clear),
        .offer      (offer),
        .pick       (pick)
    );

    assign pick_ent  = (pick == PICK_NEXT) ? ent1 : ent0;
    assign iss_valid = offer;
    assign iss_sel   = (pick == PICK_NEXT);
    assign iss_br    = pick_ent[O_BR];
    assign iss_wr    = pick_ent[O_WR];
    assign iss_dst   = pick_ent[O_DST +: RW];
    assign iss_src_a = pick_ent[O_SA +: RW];
    assign iss_src_b = pick_ent[O_SB +: RW];
    assign iss_pay   = pick_ent[O_PAY +: PAYW];

    // R8: whatever is offered has both operands available
    a_r8_operands_ready: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (reg_rdy[iss_src_a] && reg_rdy[iss_src_b]));

    // R3: an overtake happens only while the head waits on a register
    a_r3_head_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_sel) |->
            !(reg_rdy[ent0[O_SA +: RW]] && reg_rdy[ent0[O_SB +: RW]]));

    // R5: the overtaking entry never consumes the head's result
    a_r5_no_true_dep: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_sel && ent0[O_WR]) |->
            (iss_src_a != ent0[O_DST +: RW] && iss_src_b != ent0[O_DST +: RW]));

    // R6: no two writers of one register swap order
    a_r6_no_out_dep: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_sel && ent0[O_WR] && iss_wr) |->
            (iss_dst != ent0[O_DST +: RW]));

    // R9: branches neither overtake nor get overtaken
    a_r9_branch_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_sel) |-> (!iss_br && !ent0[O_BR]));

    // R1: reset leaves room for a push
    a_r1_room_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> in_ready);

endmodule

// File: tb/peek_issue_queue_tb.sv
module peek_issue_queue_tb;

    localparam int CLK_P  = 10;
    localparam int DEPTH  = 8;
    localparam int NREG   = 16;
    localparam int PAYW   = 8;
    localparam int RW     = 4;
    localparam int WD_LIM = 190000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic            in_br = 1'b0;
    logic            in_wr = 1'b0;
    logic [RW-1:0]   in_dst = '0;
    logic [RW-1:0]   in_src_a = '0;
    logic [RW-1:0]   in_src_b = '0;
    logic [PAYW-1:0] in_pay = '0;
    logic [NREG-1:0] reg_rdy = '1;
    logic            iss_valid;
    logic            iss_ready = 1'b0;
    logic            iss_sel;
    logic            iss_br;
    logic            iss_wr;
    logic [RW-1:0]   iss_dst;
    logic [RW-1:0]   iss_src_a;
    logic [RW-1:0]   iss_src_b;
    logic [PAYW-1:0] iss_pay;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_P / 2) clk = ~clk;

    peek_issue_queue #(.DEPTH(DEPTH), .NREG(NREG), .PAYW(PAYW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_br(in_br), .in_wr(in_wr),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_pay(in_pay),
        .reg_rdy(reg_rdy),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_sel(iss_sel),
        .iss_br(iss_br), .iss_wr(iss_wr), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_pay(iss_pay)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIM) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIM);
            $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push(input bit br, input bit wr, input int d, input int a,
                        input int b, input int pay);
        in_valid = 1'b1;
        in_br    = br;
        in_wr    = wr;
        in_dst   = RW'(d);
        in_src_a = RW'(a);
        in_src_b = RW'(b);
        in_pay   = PAYW'(pay);
        tick();
        in_valid = 1'b0;
    endtask

    task automatic drain();
        reg_rdy   = '1;
        iss_ready = 1'b1;
        repeat (DEPTH + 1) tick();
        iss_ready = 1'b0;
    endtask

    // packed view of the offer: {valid, sel, payload}
    function automatic int offer_word();
        if (!iss_valid) return 0;
        return (1 << 9) | (int'(iss_sel) << 8) | int'(iss_pay);
    endfunction

    // pair check: head payload 0xA1, second payload 0xB2
    task automatic pair_case(input bit hbr, input int hd, input int hsa, input int hsb,
                             input bit nbr, input bit nwr, input int nd,
                             input int nsa, input int nsb, input int rmask);
        bit r [3];
        bit hok, raw, waw, war, nok, v, s;
        int exp;
        string tag;
        for (int k = 0; k < 3; k++) r[k] = rmask[k];
        push(hbr, 1'b1, hd, hsa, hsb, 8'hA1);
        push(nbr, nwr, nd, nsa, nsb, 8'hB2);
        reg_rdy   = {13'h1FFF, 3'(rmask)};
        iss_ready = 1'b0;
        #1;
        hok = r[hsa] && r[hsb];
        nok = r[nsa] && r[nsb];
        raw = (nsa == hd) || (nsb == hd);
        waw = nwr && (nd == hd);
        war = nwr && (((nd == hsa) && !r[hsa]) || ((nd == hsb) && !r[hsb]));
        if (hok) begin
            v = 1'b1; s = 1'b0; tag = "R3";
        end else if (hbr || nbr) begin
            v = 1'b0; s = 1'b0; tag = "R9";
        end else if (raw) begin
            v = 1'b0; s = 1'b0; tag = "R5";
        end else if (waw) begin
            v = 1'b0; s = 1'b0; tag = "R6";
        end else if (war) begin
            v = 1'b0; s = 1'b0; tag = "R7";
        end else if (!nok) begin
            v = 1'b0; s = 1'b0; tag = "R8";
        end else begin
            v = 1'b1; s = 1'b1; tag = "R4";
        end
        exp = v ? ((1 << 9) | (int'(s) << 8) | (s ? 'hB2 : 'hA1)) : 0;
        check(offer_word() == exp, tag, offer_word(), exp);
        drain();
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        check(iss_valid == 1'b0, "R1 valid", int'(iss_valid), 0);
        check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

        // R2: fill to capacity, extra push ignored, order kept
        reg_rdy = '1;
        for (int i = 0; i < DEPTH; i++) push(1'b0, 1'b1, i, 1, 2, i);
        check(in_ready == 1'b0, "R2 full", int'(in_ready), 0);
        push(1'b0, 1'b1, 9, 1, 2, 8'h77);
        iss_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            check(iss_valid && !iss_sel && (iss_pay == PAYW'(i)), "R2 order",
                  offer_word(), (1 << 9) | i);
            tick();
        end
        check(iss_valid == 1'b0, "R2 ignored push", offer_word(), 0);
        iss_ready = 1'b0;

        // R10: overtake keeps head in front, rest in order, one per cycle
        reg_rdy = '1;
        reg_rdy[5] = 1'b0;
        push(1'b0, 1'b1, 6, 5, 1, 8'hA0);
        push(1'b0, 1'b1, 7, 1, 2, 8'hB0);
        push(1'b0, 1'b1, 8, 1, 2, 8'hC0);
        tick();
        check(offer_word() == 'h3B0, "R10 hold", offer_word(), 'h3B0);
        iss_ready = 1'b1;
        #1;
        check(offer_word() == 'h3B0, "R10 first", offer_word(), 'h3B0);
        tick();
        check(offer_word() == 'h3C0, "R10 second", offer_word(), 'h3C0);
        tick();
        check(offer_word() == 0, "R10 head waits", offer_word(), 0);
        reg_rdy[5] = 1'b1;
        #1;
        check(offer_word() == 'h2A0, "R10 head last", offer_word(), 'h2A0);
        tick();
        check(offer_word() == 0, "R10 empty", offer_word(), 0);
        iss_ready = 1'b0;

        // R11: eligible third entry is not considered
        reg_rdy = '1;
        reg_rdy[5] = 1'b0;
        push(1'b0, 1'b1, 6, 5, 1, 8'hA0);
        push(1'b0, 1'b1, 7, 6, 2, 8'hB0);
        push(1'b0, 1'b1, 8, 1, 2, 8'hC0);
        #1;
        check(offer_word() == 0, "R11 third", offer_word(), 0);
        drain();

        // R3..R8: sweep of three registers over all six fields
        for (int hd = 0; hd < 3; hd++)
        for (int hsa = 0; hsa < 3; hsa++)
        for (int hsb = 0; hsb < 3; hsb++)
        for (int nd = 0; nd < 3; nd++)
        for (int nsa = 0; nsa < 3; nsa++)
        for (int nsb = 0; nsb < 3; nsb++)
        for (int nwr = 0; nwr < 2; nwr++)
        for (int rm = 0; rm < 8; rm++)
            pair_case(1'b0, hd, hsa, hsb, 1'b0, nwr[0], nd, nsa, nsb, rm);

        // R9: branch on either side, otherwise independent pair
        for (int bsel = 1; bsel < 3; bsel++)
        for (int rm = 0; rm < 8; rm++)
            pair_case(bsel == 1, 0, 0, 0, bsel == 2, 1'b1, 1, 2, 2, rm);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule